// File: doc/BRIEF.md
# SPI Serial EEPROM Command Controller

This block is the slave-side command front end of a 512-byte serial EEPROM model. It works in SPI mode 0. It takes an 8-bit instruction MSB first from the serial input and decodes it. It then gathers the low address byte and either streams array bytes out on the serial output or feeds write bytes to a separate page-write engine. The ninth address bit travels inside the instruction byte. The block owns the write-enable latch and the block-protect bits. It also implements the bus pause input and the write-protect gate.

All serial pins are oversampled by the system clock through a synchronizer chain. A pause input freezes every bit counter and releases the serial output, so a paused transfer resumes at the bit where it stopped. Array data comes from a synchronous read port with one cycle of latency. An array write is handed to the engine in three steps: a push for each received data byte, then either a commit or an abort when chip select rises. The engine's busy flag appears as the write-in-progress status bit.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: Serial input is sampled on rising SCK while chip select is low, MSB first. The bit count restarts at 0 each time chip select goes low, so the first rising edge of a frame carries bit 7 of the instruction.
- R2: The instruction byte decodes as follows. `0000_x011` is READ and `0000_x010` is WRITE, with bit 3 (x) giving address bit 8. `0x06` sets write enable, `0x04` clears it, `0x05` reads status and `0x01` writes status.
- R3: After READ and the low address byte, array bytes are shifted out MSB first starting at the selected address, and the address increments after each byte. The serial output changes only on falling SCK.
- R4: The read address wraps from 0x1FF to 0x000, so a read continues until chip select rises.
- R5: The write-enable latch is set only when chip select rises right after the 8 bits of `0x06` with no further bit in the frame. `0x04` clears it.
- R6: While the pause input (holdN) is low, SCK edges are ignored and the output enable is low. After release, shifting continues at the same bit.
- R7: WRITE is accepted only with the latch set and wrProtN high. Each full data byte is pushed, and its address wraps inside the 16-byte page (bits 3:0). On chip select rising, a commit is issued if at least one byte was received, the frame ended on a byte boundary and wrProtN is still high. Otherwise an abort is issued.
- R8: While wrBusy is high, status reads still work, but READ and WRITE are refused: no rdEn, no push and no output enable. The write-enable latch clears when wrBusy falls.
- R9: The status byte is {4'b0, BP1, BP0, WEL, WIP}, with WIP at bit 0 and equal to wrBusy. A status write, accepted only with the latch set, loads bits 3:2 of its data byte into BP and clears the latch.
- R10: soOe is low whenever chip select is high or the block is not returning read or status data.
- R11: An unrecognized instruction is ignored until chip select rises. It produces no output enable, no array read and no status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock (mode 0) |
| si | input | 1 | Serial data in |
| holdN | input | 1 | Pause input, active low |
| wrProtN | input | 1 | Write protect, active low; array writes allowed only while high |
| so | output | 1 | Serial data out |
| soOe | output | 1 | Output enable for so; low means high impedance |
| rdEn | output | 1 | Array read strobe |
| rdAddr | output | 9 | Array read address |
| rdData | input | 8 | Array read data, valid the cycle after rdEn |
| wrPush | output | 1 | One received write byte for the page engine |
| wrAddr | output | 9 | Address of the pushed byte |
| wrData | output | 8 | Pushed byte |
| wrCommit | output | 1 | Start the page write of all pushed bytes |
| wrAbort | output | 1 | Discard the pushed bytes |
| wrBusy | input | 1 | Page engine write cycle in progress |

## Verification
A pin change is seen by the logic two clock cycles after it is driven. Received bytes and decode strobes follow a rising SCK edge by about four cycles. The serial output settles three cycles after a falling SCK edge. The latch update, commit or abort follows a chip-select rise by about four cycles. The bench holds each SCK phase for eight cycles, samples so in the last cycle before each rising edge and waits 24 cycles after every chip-select rise before it checks status, commit, abort or push counts. Array data for each outgoing byte is fetched within three cycles of the byte boundary, well before the falling edge that presents its MSB.

// File: rtl/spi_eep_pkg.sv
package spi_eep_pkg;

  typedef enum logic [2:0] {
    ST_OPC, ST_ADDR, ST_READ, ST_WRITE, ST_STAT, ST_WRSR, ST_WEN, ST_IGN
  } ctlState_t;

  // strobes from control to datapath, all single-cycle except drive
  typedef struct packed {
    logic setHi;      // address MSB from instruction bit 3
    logic setLo;      // low address byte from receive register
    logic incAddr;    // full-width increment (read)
    logic incPage;    // increment inside page (write)
    logic fetchArr;   // request array byte into output register
    logic fetchStat;  // load status byte into output register
    logic setWel;
    logic clrWel;
    logic loadBp;
    logic drive;      // current state returns data on so
  } dpStrobe_t;

endpackage

// File: rtl/spi_eep_datapath.sv
module spi_eep_datapath
  import spi_eep_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              si,
  input  logic              holdN,
  input  logic              wrProtN,
  input  dpStrobe_t         strb,
  input  logic              wrBusy,
  input  logic [DATA_W-1:0] rdData,
  output logic              bitTick,
  output logic              byteDone,
  output logic [DATA_W-1:0] rxByte,
  output logic              atBoundary,
  output logic              csActive,
  output logic              csRise,
  output logic              wpActive,
  output logic              welQ,
  output logic [ADDR_W-1:0] addrQ,
  output logic              rdEn,
  output logic              so,
  output logic              soOe
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [4:0] PIN_IDLE = 5'b10011; // {csN, sck, si, holdN, wrProtN}

  logic [4:0] syncQ [SYNC_STAGES];
  logic [4:0] pinS;
  logic sckPrev, csActPrev, busyPrev, rdValid, soBit;
  logic holdActive, riseTick, fallTick;
  logic [CNT_W-1:0] bitCnt;
  logic [DATA_W-1:0] shiftIn, outReg;
  logic [1:0] bpQ;
  logic [DATA_W-1:0] statusByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncQ[i] <= PIN_IDLE;
    end else begin
      syncQ[0] <= {csN, sck, si, holdN, wrProtN};
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
    end
  end

  assign pinS       = syncQ[SYNC_STAGES-1];
  assign csActive   = !pinS[4];
  assign holdActive = pinS[1];
  assign wpActive   = pinS[0];
  assign riseTick   = csActive && holdActive && pinS[3] && !sckPrev;
  assign fallTick   = csActive && holdActive && !pinS[3] && sckPrev;
  assign csRise     = csActPrev && !csActive;
  assign bitTick    = riseTick;
  assign atBoundary = (bitCnt == '0);
  assign rxByte     = shiftIn;
  assign statusByte = DATA_W'({bpQ, welQ, wrBusy});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev   <= 1'b0;
      csActPrev <= 1'b0;
      busyPrev  <= 1'b0;
      bitCnt    <= '0;
      shiftIn   <= '0;
      byteDone  <= 1'b0;
    end else begin
      sckPrev   <= pinS[3];
      csActPrev <= csActive;
      busyPrev  <= wrBusy;
      byteDone  <= riseTick && (bitCnt == LAST_BIT);
      if (!csActive) begin
        bitCnt <= '0;
      end else if (riseTick) begin
        shiftIn <= {shiftIn[DATA_W-2:0], pinS[2]};
        bitCnt  <= bitCnt + 1'b1;
      end
    end
  end

  // address register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else begin
      if (strb.setHi)   addrQ[ADDR_W-1] <= shiftIn[3];
      if (strb.setLo)   addrQ[DATA_W-1:0] <= shiftIn;
      if (strb.incAddr) addrQ <= addrQ + 1'b1;
      if (strb.incPage) addrQ[PAGE_W-1:0] <= addrQ[PAGE_W-1:0] + 1'b1;
    end
  end

  // outbound path: fetch, load, shift on falling edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdEn    <= 1'b0;
      rdValid <= 1'b0;
      outReg  <= '0;
      soBit   <= 1'b0;
    end else begin
      rdEn    <= strb.fetchArr;
      rdValid <= rdEn;
      if (rdValid)             outReg <= rdData;
      else if (strb.fetchStat) outReg <= statusByte;
      else if (fallTick)       outReg <= {outReg[DATA_W-2:0], 1'b0};
      if (fallTick) soBit <= outReg[DATA_W-1];
    end
  end

  // write-enable latch and protect bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      welQ <= 1'b0;
      bpQ  <= '0;
    end else begin
      if (strb.setWel) welQ <= 1'b1;
      else if (strb.clrWel || (busyPrev && !wrBusy)) welQ <= 1'b0;
      if (strb.loadBp) bpQ <= shiftIn[3:2];
    end
  end

  assign so   = soBit;
  assign soOe = csActive && holdActive && strb.drive;

endmodule

// File: rtl/spi_eep_control.sv
module spi_eep_control
  import spi_eep_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteDone,
  input  logic              bitTick,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              atBoundary,
  input  logic              csActive,
  input  logic              csRise,
  input  logic              wpActive,
  input  logic              welQ,
  input  logic              wrBusy,
  output dpStrobe_t         strb,
  output logic              wrPush,
  output logic              wrCommit,
  output logic              wrAbort
);
  localparam logic [DATA_W-1:0] OP_WREN = DATA_W'(8'h06);
  localparam logic [DATA_W-1:0] OP_WRDI = DATA_W'(8'h04);
  localparam logic [DATA_W-1:0] OP_RDSR = DATA_W'(8'h05);
  localparam logic [DATA_W-1:0] OP_WRSR = DATA_W'(8'h01);

  ctlState_t state, nextState;
  logic isWr, nextIsWr, gotByte, nextGotByte;
  logic memOp;

  assign memOp = (rxByte[DATA_W-1:4] == '0) && (rxByte[2:1] == 2'b01);

  always_comb begin
    strb        = '0;
    wrPush      = 1'b0;
    wrCommit    = 1'b0;
    wrAbort     = 1'b0;
    nextState   = state;
    nextIsWr    = isWr;
    nextGotByte = gotByte;
    strb.drive  = (state == ST_READ) || (state == ST_STAT);
    if (csRise) begin
      if (state == ST_WEN) strb.setWel = 1'b1;
      if (state == ST_WRITE) begin
        if (gotByte && atBoundary && wpActive) wrCommit = 1'b1;
        else wrAbort = 1'b1;
      end
      if (state == ST_ADDR && isWr) wrAbort = 1'b1;
      nextState   = ST_OPC;
      nextGotByte = 1'b0;
    end else if (!csActive) begin
      nextState   = ST_OPC;
      nextGotByte = 1'b0;
    end else begin
      case (state)
        ST_OPC: if (byteDone) begin
          if (memOp && rxByte[0]) begin
            strb.setHi = 1'b1;
            nextIsWr   = 1'b0;
            nextState  = wrBusy ? ST_IGN : ST_ADDR;
          end else if (memOp) begin
            strb.setHi = 1'b1;
            nextIsWr   = 1'b1;
            nextState  = (!wrBusy && welQ && wpActive) ? ST_ADDR : ST_IGN;
          end else if (rxByte == OP_WREN) begin
            nextState = ST_WEN;
          end else if (rxByte == OP_WRDI) begin
            strb.clrWel = 1'b1;
            nextState   = ST_IGN;
          end else if (rxByte == OP_RDSR) begin
            strb.fetchStat = 1'b1;
            nextState      = ST_STAT;
          end else if (rxByte == OP_WRSR) begin
            nextState = welQ ? ST_WRSR : ST_IGN;
          end else begin
            nextState = ST_IGN;
          end
        end
        ST_ADDR: if (byteDone) begin
          strb.setLo = 1'b1;
          if (isWr) begin
            nextState = ST_WRITE;
          end else begin
            strb.fetchArr = 1'b1;
            nextState     = ST_READ;
          end
        end
        ST_READ: if (byteDone) begin
          strb.incAddr  = 1'b1;
          strb.fetchArr = 1'b1;
        end
        ST_WRITE: if (byteDone) begin
          wrPush       = 1'b1;
          strb.incPage = 1'b1;
          nextGotByte  = 1'b1;
        end
        ST_STAT: if (byteDone) strb.fetchStat = 1'b1;
        ST_WRSR: if (byteDone) begin
          strb.loadBp = 1'b1;
          strb.clrWel = 1'b1;
          nextState   = ST_IGN;
        end
        ST_WEN: if (bitTick) nextState = ST_IGN;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_OPC;
      isWr    <= 1'b0;
      gotByte <= 1'b0;
    end else begin
      state   <= nextState;
      isWr    <= nextIsWr;
      gotByte <= nextGotByte;
    end
  end

endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
  import spi_eep_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              si,
  input  logic              holdN,
  input  logic              wrProtN,
  output logic              so,
  output logic              soOe,
  output logic              rdEn,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic              wrPush,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              wrCommit,
  output logic              wrAbort,
  input  logic              wrBusy
);
  dpStrobe_t strb;
  logic bitTick, byteDone, atBoundary, csActive, csRise, wpActive, welQ;
  logic [DATA_W-1:0] rxByte;
  logic [ADDR_W-1:0] addrQ;

  spi_eep_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .holdN(holdN),
    .wrProtN(wrProtN), .strb(strb), .wrBusy(wrBusy), .rdData(rdData),
    .bitTick(bitTick), .byteDone(byteDone), .rxByte(rxByte),
    .atBoundary(atBoundary), .csActive(csActive), .csRise(csRise),
    .wpActive(wpActive), .welQ(welQ), .addrQ(addrQ), .rdEn(rdEn),
    .so(so), .soOe(soOe)
  );

  spi_eep_control #(.DATA_W(DATA_W)) ctl_i (
    .clk(clk), .rstN(rstN), .byteDone(byteDone), .bitTick(bitTick),
    .rxByte(rxByte), .atBoundary(atBoundary), .csActive(csActive),
    .csRise(csRise), .wpActive(wpActive), .welQ(welQ), .wrBusy(wrBusy),
    .strb(strb), .wrPush(wrPush), .wrCommit(wrCommit), .wrAbort(wrAbort)
  );

  assign rdAddr = addrQ;
  assign wrAddr = addrQ;
  assign wrData = rxByte;

endmodule

// File: rtl/spi_eeprom_ctrl_chk.sv
module spi_eeprom_ctrl_chk #(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              holdN,
  input logic              wrProtN,
  input logic              soOe,
  input logic              rdEn,
  input logic              wrPush,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              wrCommit,
  input logic              wrAbort,
  input logic              wrBusy
);
  logic [2:0] upCnt;
  logic havePush;
  logic [ADDR_W-1:0] lastAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upCnt    <= '0;
      havePush <= 1'b0;
      lastAddr <= '0;
    end else begin
      if (upCnt != 3'd7) upCnt <= upCnt + 1'b1;
      if (wrCommit || wrAbort) havePush <= 1'b0;
      else if (wrPush) havePush <= 1'b1;
      if (wrPush) lastAddr <= wrAddr;
    end
  end

  assert_hiz_cs_high_R10: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 3'd4 && csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> !soOe);

  assert_hiz_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 3'd4 && !holdN && !$past(holdN) && !$past(holdN, 2) && !$past(holdN, 3)) |-> !soOe);

  assert_commit_abort_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(wrCommit && wrAbort));

  assert_commit_needs_wp_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |-> wrProtN);

  assert_push_same_page_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrPush && havePush) |-> (wrAddr[ADDR_W-1:PAGE_W] == lastAddr[ADDR_W-1:PAGE_W]));

  assert_no_read_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> !wrBusy);

  assert_no_push_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrPush |-> !wrBusy);

endmodule

bind spi_eeprom_ctrl spi_eeprom_ctrl_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) chk_i (.*);

// File: tb/spi_eeprom_ctrl_tb.sv
module spi_eeprom_ctrl_tb_top;
  localparam int HALF     = 8;
  localparam int BUSY_CYC = 1000;

  logic clk = 1'b0;
  logic rstN, csN, sck, si, holdN, wrProtN;
  logic so, soOe, rdEn, wrPush, wrCommit, wrAbort;
  logic wrBusy;
  logic [8:0] rdAddr, wrAddr;
  logic [7:0] rdData, wrData;

  always #5 clk = ~clk;

  spi_eeprom_ctrl dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .holdN(holdN),
    .wrProtN(wrProtN), .so(so), .soOe(soOe), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .wrPush(wrPush), .wrAddr(wrAddr), .wrData(wrData),
    .wrCommit(wrCommit), .wrAbort(wrAbort), .wrBusy(wrBusy)
  );

  int chkCnt = 0, failCnt = 0;
  int oeCnt = 0, rdCnt = 0, commitCnt = 0, abortCnt = 0, pbN = 0, busyCnt = 0;
  logic [7:0] mem [512];
  logic [7:0] expMem [512];
  logic [8:0] pbA [32];
  logic [7:0] pbD [32];

  function automatic logic [7:0] initVal(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  // array and page-write engine model
  always @(posedge clk) begin
    if (soOe) oeCnt <= oeCnt + 1;
    if (rdEn) begin
      rdData <= mem[rdAddr];
      rdCnt  <= rdCnt + 1;
    end
    if (!rstN) begin
      wrBusy <= 1'b0;
      pbN    <= 0;
    end else begin
      if (wrPush && pbN < 32) begin
        pbA[pbN] <= wrAddr;
        pbD[pbN] <= wrData;
        pbN      <= pbN + 1;
      end
      if (wrAbort) begin
        pbN      <= 0;
        abortCnt <= abortCnt + 1;
      end
      if (wrCommit) begin
        commitCnt <= commitCnt + 1;
        wrBusy    <= 1'b1;
        busyCnt   <= BUSY_CYC;
      end else if (wrBusy) begin
        if (busyCnt == 1) begin
          for (int k = 0; k < pbN; k++) mem[pbA[k]] <= pbD[k];
          pbN    <= 0;
          wrBusy <= 1'b0;
        end
        busyCnt <= busyCnt - 1;
      end
    end
  end

  task automatic check(input logic ok, input string what, input int act, input int exp);
    chkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  task automatic doHold();
    repeat (HALF) @(negedge clk);
    holdN <= 1'b0;
    repeat (6) @(negedge clk);
    check(soOe == 1'b0, "R6 output enable during pause", int'(soOe), 0);
    for (int t = 0; t < 2; t++) begin
      sck <= 1'b1; repeat (4) @(negedge clk);
      sck <= 1'b0; repeat (4) @(negedge clk);
    end
    holdN <= 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nb, input int holdBit,
                      output logic [7:0] rx);
    rx = '0;
    for (int b = 7; b >= 8 - nb; b--) begin
      if (b == holdBit) doHold();
      si <= tx[b];
      repeat (HALF) @(negedge clk);
      rx[b] = so;
      sck <= 1'b1;
      repeat (HALF) @(negedge clk);
      sck <= 1'b0;
    end
  endtask

  task automatic csLow();
    csN <= 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic csHigh();
    repeat (HALF) @(negedge clk);
    csN <= 1'b1;
    repeat (3 * HALF) @(negedge clk);
  endtask

  task automatic sendOp(input logic [7:0] op);
    logic [7:0] d;
    csLow(); xfer(op, 8, -1, d); csHigh();
  endtask

  task automatic readStatus(output logic [7:0] st);
    logic [7:0] d;
    csLow(); xfer(8'h05, 8, -1, d); xfer(8'h00, 8, -1, st); csHigh();
  endtask

  task automatic test_reset();
    logic [7:0] st;
    check(soOe == 1'b0, "R10 output enable after reset", int'(soOe), 0);
    readStatus(st);
    check(st == 8'h00, "R9 status after reset", st, 8'h00);
  endtask

  task automatic test_unknown();
    logic [7:0] d, st;
    int oe0, rd0;
    oe0 = oeCnt; rd0 = rdCnt;
    csLow(); xfer(8'hA5, 8, -1, d); xfer(8'h03, 8, -1, d); xfer(8'h00, 8, -1, d); csHigh();
    check(oeCnt == oe0, "R11 no output enable after unknown opcode", oeCnt - oe0, 0);
    check(rdCnt == rd0, "R11 no array read after unknown opcode", rdCnt - rd0, 0);
    readStatus(st);
    check(st == 8'h00, "R11 status unchanged", st, 8'h00);
  endtask

  task automatic test_wel();
    logic [7:0] d, st;
    csLow(); xfer(8'h06, 8, -1, d); xfer(8'h02, 8, -1, d); csHigh();
    readStatus(st);
    check(st == 8'h00, "R5 latch not set when frame continues", st, 8'h00);
    sendOp(8'h06);
    readStatus(st);
    check(st == 8'h02, "R5 latch set after lone 0x06", st, 8'h02);
    sendOp(8'h04);
    readStatus(st);
    check(st == 8'h00, "R5 latch cleared by 0x04", st, 8'h00);
  endtask

  task automatic test_write_no_wel();
    logic [7:0] d;
    int c0, a0;
    c0 = commitCnt; a0 = abortCnt;
    csLow(); xfer(8'h02, 8, -1, d); xfer(8'h40, 8, -1, d); xfer(8'h99, 8, -1, d); csHigh();
    check(commitCnt == c0 && pbN == 0, "R7 write refused without latch", commitCnt - c0, 0);
    check(abortCnt == a0, "R7 refused write sends no abort", abortCnt - a0, 0);
  endtask

  task automatic test_page_write();
    logic [7:0] d, st;
    logic [7:0] wb [4];
    int c0, oe0, rd0;
    wb[0] = 8'hA1; wb[1] = 8'hB2; wb[2] = 8'hC3; wb[3] = 8'hD4;
    c0 = commitCnt;
    sendOp(8'h06);
    csLow(); xfer(8'h0A, 8, -1, d); xfer(8'h0E, 8, -1, d);
    for (int k = 0; k < 4; k++) xfer(wb[k], 8, -1, d);
    csHigh();
    for (int k = 0; k < 4; k++) expMem[9'h100 | ((14 + k) & 15)] = wb[k];
    check(commitCnt == c0 + 1, "R7 commit after whole bytes", commitCnt - c0, 1);
    check(pbA[0] == 9'h10E && pbA[1] == 9'h10F, "R2 R7 push addresses before wrap", pbA[1], 9'h10F);
    check(pbA[2] == 9'h100 && pbA[3] == 9'h101, "R7 page wrap of push address", pbA[2], 9'h100);
    readStatus(st);
    check(st == 8'h03, "R8 R9 status during write cycle", st, 8'h03);
    oe0 = oeCnt; rd0 = rdCnt;
    csLow(); xfer(8'h03, 8, -1, d); xfer(8'h00, 8, -1, d); xfer(8'h00, 8, -1, d); csHigh();
    check(oeCnt == oe0 && rdCnt == rd0, "R8 read refused while busy", rdCnt - rd0, 0);
    check(wrBusy == 1'b1, "R8 busy still high for refused read", int'(wrBusy), 1);
    while (wrBusy) @(negedge clk);
    repeat (4 * HALF) @(negedge clk);
    readStatus(st);
    check(st == 8'h00, "R8 latch cleared when cycle ends", st, 8'h00);
    csLow(); xfer(8'h0B, 8, -1, d); xfer(8'h00, 8, -1, d);
    for (int k = 0; k < 3; k++) begin
      xfer(8'h00, 8, -1, d);
      check(d == expMem[9'h100 + k], "R3 R1 read back written page", d, expMem[9'h100 + k]);
    end
    csHigh();
  endtask

  task automatic test_read_wrap();
    logic [7:0] d;
    logic [8:0] a;
    csLow(); xfer(8'h0B, 8, -1, d); xfer(8'hFE, 8, -1, d);
    for (int k = 0; k < 4; k++) begin
      a = 9'(9'h1FE + k);
      xfer(8'h00, 8, -1, d);
      check(d == expMem[a], "R4 read across top address", d, expMem[a]);
    end
    csHigh();
  endtask

  task automatic test_hold();
    logic [7:0] d;
    csLow(); xfer(8'h03, 8, -1, d); xfer(8'h20, 8, 2, d);
    xfer(8'h00, 8, 4, d);
    check(d == expMem[9'h020], "R6 byte with pause inside", d, expMem[9'h020]);
    xfer(8'h00, 8, -1, d);
    check(d == expMem[9'h021], "R6 R3 byte after paused byte", d, expMem[9'h021]);
    csHigh();
  endtask

  task automatic test_wp();
    logic [7:0] d, st;
    int c0;
    c0 = commitCnt;
    sendOp(8'h06);
    wrProtN <= 1'b0;
    repeat (4) @(negedge clk);
    csLow(); xfer(8'h02, 8, -1, d); xfer(8'h10, 8, -1, d); xfer(8'h55, 8, -1, d); csHigh();
    check(commitCnt == c0, "R7 write refused with protect low", commitCnt - c0, 0);
    wrProtN <= 1'b1;
    repeat (4) @(negedge clk);
    readStatus(st);
    check(st == 8'h02, "R7 latch kept after refused write", st, 8'h02);
    sendOp(8'h04);
  endtask

  task automatic test_abort();
    logic [7:0] d;
    int c0, a0;
    c0 = commitCnt; a0 = abortCnt;
    sendOp(8'h06);
    csLow(); xfer(8'h02, 8, -1, d); xfer(8'h30, 8, -1, d); xfer(8'h77, 8, -1, d);
    xfer(8'h88, 3, -1, d); csHigh();
    check(commitCnt == c0, "R7 no commit on partial byte", commitCnt - c0, 0);
    check(abortCnt == a0 + 1, "R7 abort on partial byte", abortCnt - a0, 1);
    sendOp(8'h04);
  endtask

  task automatic test_wrsr();
    logic [7:0] d, st;
    sendOp(8'h06);
    csLow(); xfer(8'h01, 8, -1, d); xfer(8'hFF, 8, -1, d); csHigh();
    readStatus(st);
    check(st == 8'h0C, "R9 protect bits loaded, latch cleared", st, 8'h0C);
    csLow(); xfer(8'h01, 8, -1, d); xfer(8'h00, 8, -1, d); csHigh();
    readStatus(st);
    check(st == 8'h0C, "R9 status write ignored without latch", st, 8'h0C);
    sendOp(8'h06);
    csLow(); xfer(8'h01, 8, -1, d); xfer(8'h08, 8, -1, d); csHigh();
    readStatus(st);
    check(st == 8'h08, "R9 only bits 3:2 taken", st, 8'h08);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin
      mem[i]    = initVal(i);
      expMem[i] = initVal(i);
    end
    rstN = 1'b0; csN = 1'b1; sck = 1'b0; si = 1'b0; holdN = 1'b1; wrProtN = 1'b1;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    test_reset();
    test_unknown();
    test_wel();
    test_write_no_wel();
    test_page_write();
    test_read_wrap();
    test_hold();
    test_wp();
    test_abort();
    test_wrsr();
    $display("End of test - %0d assertions evaluated, %0d failures", chkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chkCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", chkCnt, failCnt);
    $finish;
  end

endmodule